// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block sits between an execution side and a byte-wide memory. While the execution side is busy, it reads the next instruction bytes ahead of time and keeps them in a small first-in first-out queue. The execution side takes bytes from the head of that queue through a valid/pop pair. Every code address is formed from a 16-bit code segment and a 16-bit fetch offset as segment times sixteen plus offset, truncated to 20 bits.

The execution side can also ask for a single data byte to be read or written at its own segment and offset. That request takes the memory port ahead of any further prefetch. A prefetch cycle that is already on the bus is allowed to finish first. A flush loads a new code segment and offset, empties the queue and throws away the byte of any prefetch still in flight. Fetching then restarts at the new address.

Top module: `prefetch_queue`

## Requirements
- R1: The queue never holds more than QDEPTH bytes (default 6). No prefetch cycle starts unless a slot will be free, so with a full queue and no data request, `mem_req` stays low.
- R2: Every memory address is `{seg, 4'h0} + {4'h0, ofs}` taken modulo 2^20. For example, A4FB:4872 gives A9822 and FFFF:0010 gives 00000.
- R3: Prefetched bytes reach `q_byte` in fetch order. The fetch offset advances by one for each prefetch cycle issued and wraps at 16 bits, while the segment stays unchanged.
- R4: A data request raised during a prefetch cycle waits only for that cycle to end. The next memory cycle is the data transfer, ahead of any further prefetch.
- R5: A flush that is high at a clock edge loads `flush_seg`/`flush_ofs` as the new fetch position. After that edge `q_valid` is low, and the byte of a prefetch in flight at the flush is never queued.
- R6: `q_valid` is low whenever the queue is empty. A `q_pop` while `q_valid` is low has no effect on what is later delivered.
- R7: Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` hold steady until the edge where `mem_ack` is high, which ends the cycle.
- R8: A data transfer ends with `dack` high in the cycle of its `mem_ack`, and `drdata` equals `mem_rdata` in that cycle. A write drives `mem_we` = 1 and `mem_wdata` = `dwdata`.
- R9: While `rst_n` is low, `mem_req` and `q_valid` are low, and the fetch position is 0000:0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Load a new fetch position and empty the queue |
| flush_seg | input | 16 | New code segment |
| flush_ofs | input | 16 | New fetch offset |
| dreq | input | 1 | Execution-side data transfer request, held until `dack` |
| dwe | input | 1 | 1 = write, 0 = read for the data transfer |
| dseg | input | 16 | Segment of the data transfer |
| dofs | input | 16 | Offset of the data transfer |
| dwdata | input | 8 | Write data |
| dack | output | 1 | Data transfer completes this cycle |
| drdata | output | 8 | Read data, valid with `dack` |
| q_valid | output | 1 | Queue head holds a byte |
| q_byte | output | 8 | Queue head byte |
| q_pop | input | 1 | Remove the head byte |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory completes the cycle |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the unit with the default queue depth of six. Its memory model answers every request after two wait cycles. With that depth and latency, the queue can be filled until prefetching stalls. A data request can also land inside a prefetch cycle, and a flush can arrive while a prefetch byte is still on its way. The address vectors include segment/offset pairs whose sum runs past 20 bits and offsets that wrap during fetching.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int QDEPTH = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [15:0] flush_seg,
  input  logic [15:0] flush_ofs,
  input  logic        dreq,
  input  logic        dwe,
  input  logic [15:0] dseg,
  input  logic [15:0] dofs,
  input  logic [7:0]  dwdata,
  output logic        dack,
  output logic [7:0]  drdata,
  output logic        q_valid,
  output logic [7:0]  q_byte,
  input  logic        q_pop,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  logic [15:0]   cs_q, ip_q;
  logic          busy, own_data, cancel;
  logic [7:0]    qmem [QDEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          done, push, pop, free, start_d, start_p, room;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign done    = busy & mem_ack;
  assign dack    = done & own_data;
  assign drdata  = mem_rdata;
  assign push    = done & ~own_data & ~cancel & ~flush;
  assign pop     = q_valid & q_pop & ~flush;
  assign free    = ~busy | mem_ack;
  assign start_d = free & dreq & ~dack;
  assign room    = ({1'b0, cnt} + {{CW{1'b0}}, push}) < (CW + 1)'(QDEPTH);
  assign start_p = free & ~start_d & ~flush & room;
  assign mem_req = busy;
  assign q_valid = (cnt != '0);
  assign q_byte  = qmem[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      own_data  <= 1'b0;
      cancel    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (free) begin
      busy     <= start_d | start_p;
      own_data <= start_d;
      cancel   <= 1'b0;
      mem_we   <= start_d & dwe;
      if (start_d) begin
        mem_addr  <= phys(dseg, dofs);
        mem_wdata <= dwdata;
      end else if (start_p) begin
        mem_addr <= phys(cs_q, ip_q);
      end
    end else if (flush && !own_data) begin
      cancel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= '0;
      ip_q <= '0;
    end else if (flush) begin
      cs_q <= flush_seg;
      ip_q <= flush_ofs;
    end else if (start_p) begin
      ip_q <= ip_q + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= nxt(wr_p);
      if (pop)  rd_p <= nxt(rd_p);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) qmem[wr_p] <= mem_rdata;
  end
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int QDEPTH = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         flush,
  input logic                         dreq,
  input logic                         dwe,
  input logic                         dack,
  input logic                         q_valid,
  input logic                         mem_req,
  input logic                         mem_we,
  input logic [19:0]                  mem_addr,
  input logic [7:0]                   mem_wdata,
  input logic                         mem_ack,
  input logic [$clog2(QDEPTH+1)-1:0]  cnt
);
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(QDEPTH+1))'(QDEPTH));

  a_r1_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ($clog2(QDEPTH+1))'(QDEPTH) && !mem_req && !dreq) |=> !mem_req);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_valid);

  a_r8_dack_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (mem_req && mem_ack));

  a_r4_data_next: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && dreq && !dack) |=> (mem_req && mem_we == $past(dwe)));
endmodule

bind prefetch_queue prefetch_queue_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .dreq(dreq), .dwe(dwe), .dack(dack),
  .q_valid(q_valid), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .cnt(cnt)
);

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic flush = 0, dreq = 0, dwe = 0, q_pop = 0, mem_ack = 0;
  logic [15:0] flush_seg = 0, flush_ofs = 0, dseg = 0, dofs = 0;
  logic [7:0] dwdata = 0, mem_rdata = 0;
  logic dack, q_valid, mem_req, mem_we;
  logic [7:0] drdata, q_byte, mem_wdata;
  logic [19:0] mem_addr;

  int errors = 0, checks = 0, lat = 0, nacks = 0;
  logic [19:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  prefetch_queue #(.QDEPTH(6)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg), .flush_ofs(flush_ofs),
    .dreq(dreq), .dwe(dwe), .dseg(dseg), .dofs(dofs), .dwdata(dwdata),
    .dack(dack), .drdata(drdata), .q_valid(q_valid), .q_byte(q_byte), .q_pop(q_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mval(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; lat <= 0;
    end else if (mem_ack) begin
      mem_ack <= 0; lat <= 0;
    end else if (mem_req) begin
      if (lat >= LAT) begin
        mem_ack   <= 1;
        mem_rdata <= mval(mem_addr);
        nacks     <= nacks + 1;
        if (mem_we) begin wr_addr <= mem_addr; wr_data <= mem_wdata; end
      end else lat <= lat + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    @(negedge clk); flush = 1; flush_seg = s; flush_ofs = o;
    @(negedge clk); flush = 0;
  endtask

  task automatic pop_check(input logic [7:0] exp, input string req);
    int t = 0;
    while (1) begin
      @(negedge clk); #2;
      if (q_valid) break;
      if (++t > 200) begin check(0, {req, " timeout"}, 0, exp); return; end
    end
    check(q_byte == exp, req, q_byte, exp);
    q_pop = 1;
    @(posedge clk); #1 q_pop = 0;
  endtask

  task automatic data_xfer(input logic [15:0] s, input logic [15:0] o, input bit w,
                           input logic [7:0] wd, output logic [7:0] rd);
    int t = 0;
    dreq = 1; dwe = w; dseg = s; dofs = o; dwdata = wd; rd = 0;
    while (1) begin
      @(negedge clk); #2;
      if (dack) begin rd = drdata; break; end
      if (++t > 200) begin check(0, "R8 data timeout", 0, 1); break; end
    end
    @(posedge clk); #1 dreq = 0;
  endtask

  localparam logic [51:0] TBL [6] = '{
    {16'hA4FB, 16'h4872, 20'hA9822},
    {16'h0000, 16'h0000, 20'h00000},
    {16'hFFFF, 16'h0010, 20'h00000},
    {16'h1234, 16'h5678, 20'h179B8},
    {16'hFFFF, 16'hFFFF, 20'h0FFEF},
    {16'h4000, 16'h0001, 20'h40001}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int n0;
    repeat (3) @(negedge clk);
    #2;
    check(mem_req == 0, "R9 reset mem_req", mem_req, 0);
    check(q_valid == 0, "R9 reset q_valid", q_valid, 0);
    @(negedge clk); rst_n = 1;
    pop_check(mval(20'h00000), "R9 first fetch at 0000:0000");

    for (int i = 0; i < 6; i++) begin
      logic [15:0] s = TBL[i][51:36];
      logic [15:0] o = TBL[i][35:20];
      logic [19:0] e = TBL[i][19:0];
      do_flush(s, o);
      #2 check(q_valid == 0, "R5 flush empties", q_valid, 0);
      check(phys(s, o) == e, "R2 vector table", phys(s, o), e);
      pop_check(mval(e), "R2 first byte address");
      for (int k = 1; k < 3; k++)
        pop_check(mval(phys(s, o + 16'(k))), "R3 sequential bytes");
    end

    do_flush(16'h1234, 16'h0000);
    repeat (40) @(negedge clk);
    #2 check(mem_req == 0, "R1 stops when full", mem_req, 0);
    check(q_valid == 1, "R1 queue holds bytes", q_valid, 1);
    for (int k = 0; k < 7; k++)
      pop_check(mval(phys(16'h1234, 16'(k))), "R1 six queued then continues");

    do_flush(16'h2222, 16'h0100);
    #2 check(q_valid == 0, "R6 empty valid low", q_valid, 0);
    q_pop = 1; @(posedge clk); #1 q_pop = 0;
    pop_check(mval(phys(16'h2222, 16'h0100)), "R6 empty pop ignored");

    do_flush(16'h2000, 16'h0000);
    begin
      int t = 0;
      while (!(mem_req && !mem_we) && t < 50) begin @(negedge clk); #2; t++; end
    end
    n0 = nacks;
    data_xfer(16'h3000, 16'h0005, 0, 8'h00, rd);
    check(nacks - n0 <= 2, "R4 data next after prefetch", nacks - n0, 2);
    check(rd == mval(20'h30005), "R8 read data", rd, mval(20'h30005));
    data_xfer(16'h0100, 16'h0001, 1, 8'hA5, rd);
    check(wr_addr == 20'h01001, "R8 write address", wr_addr, 20'h01001);
    check(wr_data == 8'hA5, "R8 write data", wr_data, 8'hA5);

    do_flush(16'h5000, 16'h0000);
    begin
      int t = 0;
      @(negedge clk); #2;
      while (!(mem_req && !mem_we && lat == 0) && t < 50) begin @(negedge clk); #2; t++; end
    end
    do_flush(16'h6000, 16'h0010);
    #2 check(q_valid == 0, "R5 flush during fetch", q_valid, 0);
    pop_check(mval(20'h60010), "R5 in-flight byte dropped");
    pop_check(mval(20'h60011), "R3 after flush");

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule